// File: doc/BRIEF.md
# Microframe USB Traffic Source Arbiter

This block decides, inside every high-speed USB microframe, which of three packet sources owns the bus. The three sources are a debug channel, a periodic DMA engine and an asynchronous DMA engine. Access is handed out in time slots, not by rotation and not by a plain priority pick. The debug channel can only start when the microframe begins. After that comes the periodic work for the current microframe. Asynchronous traffic then fills whatever time is left, up to the end-of-window cutoff.

A one-cycle start-of-microframe strobe opens each slot sequence. The sources raise level requests. A budget input tells the arbiter whether the transaction it is about to grant can finish before the cutoff. A granted source keeps the bus until it pulses done. The arbiter also drives a port enable vector: while the debug channel runs, only the debug port is enabled and every other downstream port stays idle. A flush strobe tells the periodic engine to discard work it still holds from the microframe that just ended.

Top module: `uframe_arbiter`

## Requirements
- R1: After reset, and at any time before the first start-of-microframe strobe, the grant vector and the port enable vector are all zero.
- R2: The debug grant (grant bit 0) is issued only on the clock edge where `sof_i` is high, the arbiter is not busy, `dbg_req_i` is high and `fits_i` is high. A debug request raised at any other time is not granted in that microframe.
- R3: A start-of-microframe strobe with no debug request moves the arbiter into the periodic phase. The periodic phase also follows completion of a debug transaction. In the periodic phase a pending periodic request with `fits_i` high gets the periodic grant (bit 1) one edge later, and this takes precedence over an asynchronous request.
- R4: When the periodic phase sees no periodic request, the arbiter moves to the asynchronous phase. There, a pending asynchronous request with `fits_i` high gets the asynchronous grant (bit 2). Periodic requests get no grant in the asynchronous phase until the next start-of-microframe.
- R5: If `eof_i` is high while the arbiter is idle inside a microframe, no grant is issued, and none is issued until the next start-of-microframe strobe.
- R6: If `fits_i` is low when a grant decision is taken, no grant is issued, and the arbiter stays idle until the next start-of-microframe strobe.
- R7: Grants are non-preemptive: a grant stays unchanged until `done_i` is sampled high. If a start-of-microframe strobe arrives while a grant is held, the debug slot of that microframe is lost, and the arbiter enters the periodic phase once `done_i` arrives.
- R8: The grant vector is one-hot or all zero. Bit 0 is debug, bit 1 is periodic, bit 2 is asynchronous.
- R9: While the debug grant is held, `port_en_o` has only bit `DBG_PORT` (port 0 by default) set. Under any other grant all port bits are set, and with no grant all bits are clear.
- R10: `per_flush_o` is high exactly in the cycles where `sof_i` and `per_req_i` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | Start-of-microframe strobe |
| eof_i | input | 1 | End-of-window reached; no new transaction may start |
| dbg_req_i | input | 1 | Debug channel has a transaction pending |
| per_req_i | input | 1 | Periodic engine has work for this microframe |
| async_req_i | input | 1 | Asynchronous engine has work pending |
| fits_i | input | 1 | The candidate transaction finishes before the cutoff |
| done_i | input | 1 | The granted source has finished its transaction |
| grant_o | output | 3 | One-hot grant: bit 0 debug, bit 1 periodic, bit 2 asynchronous |
| port_en_o | output | NUM_PORTS | Downstream port enable mask |
| per_flush_o | output | 1 | Drop leftover periodic work of the ended microframe |

## Verification
The bench builds the arbiter with `NUM_PORTS` = 5 and `DBG_PORT` = 0. With five ports, a port mask stuck at four bits, or a debug mask aimed at the wrong bit, shows up at the ports. The table walks whole microframes with long sequences. These include a late debug request, periodic traffic outranking asynchronous traffic, a budget refusal, the cutoff, and a start strobe landing on a held grant, including the cycle where it coincides with done. Directed tests then cover reset during a held grant.

// File: rtl/uarb_pkg.sv
package uarb_pkg;

  localparam int NUM_SRC = 3;
  localparam int SRC_DBG = 0;
  localparam int SRC_PER = 1;
  localparam int SRC_ASY = 2;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_PER    = 3'd1,
    ST_ASY    = 3'd2,
    ST_BUSY_D = 3'd3,
    ST_BUSY_P = 3'd4,
    ST_BUSY_A = 3'd5
  } uarb_state_e;

  function automatic logic is_busy(uarb_state_e s);
    return (s == ST_BUSY_D) || (s == ST_BUSY_P) || (s == ST_BUSY_A);
  endfunction

  function automatic logic [NUM_SRC-1:0] grant_of(uarb_state_e s);
    logic [NUM_SRC-1:0] g;
    g = '0;
    case (s)
      ST_BUSY_D: g[SRC_DBG] = 1'b1;
      ST_BUSY_P: g[SRC_PER] = 1'b1;
      ST_BUSY_A: g[SRC_ASY] = 1'b1;
      default:   g = '0;
    endcase
    return g;
  endfunction

  // Phase the arbiter returns to after a transaction ends.
  function automatic uarb_state_e resume_of(uarb_state_e s, logic new_frame);
    if (new_frame || s != ST_BUSY_A) return ST_PER;
    return ST_ASY;
  endfunction

endpackage

// File: rtl/uarb_seq.sv
module uarb_seq
  import uarb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sof_i,
  input  logic        eof_i,
  input  logic        dbg_req_i,
  input  logic        per_req_i,
  input  logic        async_req_i,
  input  logic        fits_i,
  input  logic        done_i,
  output uarb_state_e state_o,
  output logic        frame_start_o,
  output logic        flush_o
);

  uarb_state_e state_q, state_d;
  logic        restart_q, restart_d;
  logic        busy;

  assign busy          = is_busy(state_q);
  assign frame_start_o = sof_i && !busy;
  assign flush_o       = sof_i && per_req_i;
  assign state_o       = state_q;

  always_comb begin
    state_d   = state_q;
    restart_d = restart_q;
    if (busy) begin
      if (done_i) begin
        state_d   = resume_of(state_q, restart_q || sof_i);
        restart_d = 1'b0;
      end else begin
        restart_d = restart_q || sof_i;
      end
    end else if (frame_start_o) begin
      if (dbg_req_i) state_d = fits_i ? ST_BUSY_D : ST_OFF;
      else           state_d = ST_PER;
    end else begin
      case (state_q)
        ST_PER: begin
          if (eof_i)          state_d = ST_OFF;
          else if (per_req_i) state_d = fits_i ? ST_BUSY_P : ST_OFF;
          else                state_d = ST_ASY;
        end
        ST_ASY: begin
          if (eof_i)            state_d = ST_OFF;
          else if (async_req_i) state_d = fits_i ? ST_BUSY_A : ST_OFF;
          else                  state_d = ST_ASY;
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_OFF;
      restart_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      restart_q <= restart_d;
    end
  end

endmodule

// File: rtl/uarb_outmap.sv
module uarb_outmap
  import uarb_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DBG_PORT  = 0
) (
  input  uarb_state_e          state_i,
  output logic [NUM_SRC-1:0]   grant_o,
  output logic [NUM_PORTS-1:0] port_en_o
);

  logic any_grant;
  logic dbg_run;

  assign grant_o   = grant_of(state_i);
  assign any_grant = |grant_o;
  assign dbg_run   = grant_o[SRC_DBG];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    if (p == DBG_PORT) begin : g_dbg
      assign port_en_o[p] = any_grant;
    end else begin : g_other
      assign port_en_o[p] = any_grant && !dbg_run;
    end
  end

endmodule

// File: rtl/uframe_arbiter.sv
module uframe_arbiter
  import uarb_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DBG_PORT  = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sof_i,
  input  logic                 eof_i,
  input  logic                 dbg_req_i,
  input  logic                 per_req_i,
  input  logic                 async_req_i,
  input  logic                 fits_i,
  input  logic                 done_i,
  output logic [2:0]           grant_o,
  output logic [NUM_PORTS-1:0] port_en_o,
  output logic                 per_flush_o
);

  uarb_state_e state;
  logic        frame_start;

  uarb_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .sof_i         (sof_i),
    .eof_i         (eof_i),
    .dbg_req_i     (dbg_req_i),
    .per_req_i     (per_req_i),
    .async_req_i   (async_req_i),
    .fits_i        (fits_i),
    .done_i        (done_i),
    .state_o       (state),
    .frame_start_o (frame_start),
    .flush_o       (per_flush_o)
  );

  uarb_outmap #(
    .NUM_PORTS (NUM_PORTS),
    .DBG_PORT  (DBG_PORT)
  ) u_out (
    .state_i   (state),
    .grant_o   (grant_o),
    .port_en_o (port_en_o)
  );

endmodule

// File: rtl/uframe_arbiter_chk.sv
module uframe_arbiter_chk #(
  parameter int NUM_PORTS = 4,
  parameter int DBG_PORT  = 0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sof_i,
  input logic                 eof_i,
  input logic                 fits_i,
  input logic                 done_i,
  input logic [2:0]           grant_o,
  input logic [NUM_PORTS-1:0] port_en_o
);

  localparam logic [NUM_PORTS-1:0] DBG_MASK = NUM_PORTS'(1) << DBG_PORT;

  assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  assert_hold_until_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != 3'b000 && !done_i) |=> grant_o == $past(grant_o));

  assert_debug_at_sof_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_o[0]) |-> $past(sof_i));

  assert_debug_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o[0] |-> port_en_o == DBG_MASK);

  assert_eof_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_i && grant_o == 3'b000 && !sof_i) |=> grant_o == 3'b000);

  assert_budget_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fits_i && grant_o == 3'b000) |=> grant_o == 3'b000);

endmodule

bind uframe_arbiter uframe_arbiter_chk #(
  .NUM_PORTS (NUM_PORTS),
  .DBG_PORT  (DBG_PORT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sof_i     (sof_i),
  .eof_i     (eof_i),
  .fits_i    (fits_i),
  .done_i    (done_i),
  .grant_o   (grant_o),
  .port_en_o (port_en_o)
);

// File: tb/uframe_arbiter_test.sv
module uframe_arbiter_test;

  localparam int NP = 5;
  localparam int DP = 0;
  localparam int NV = 35;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sof = 0, eof = 0, dbg = 0, per = 0, asy = 0, fits = 0, done = 0;
  logic [2:0]    gnt;
  logic [NP-1:0] pen;
  logic          flush;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  uframe_arbiter #(.NUM_PORTS(NP), .DBG_PORT(DP)) uut (
    .clk(clk), .rst_n(rst_n), .sof_i(sof), .eof_i(eof), .dbg_req_i(dbg),
    .per_req_i(per), .async_req_i(asy), .fits_i(fits), .done_i(done),
    .grant_o(gnt), .port_en_o(pen), .per_flush_o(flush)
  );

  // {sof eof dbg per asy fits done, flush_exp, grant_exp[2:0] (async,per,dbg)}
  localparam logic [10:0] VEC [NV] = '{
    11'b0000000_0_000, 11'b0001000_0_000, 11'b1011010_1_001, 11'b0001010_0_001,
    11'b0001001_0_000, 11'b0001010_0_010, 11'b0011001_0_000, 11'b0011010_0_010,
    11'b0000001_0_000, 11'b0000110_0_000, 11'b0000110_0_100, 11'b0001101_0_000,
    11'b0001110_0_100, 11'b0000101_0_000, 11'b0000100_0_000, 11'b0000110_0_000,
    11'b1000110_0_000, 11'b0000110_0_000, 11'b0100110_0_000, 11'b0000110_0_000,
    11'b1010000_0_000, 11'b0001010_0_000, 11'b1001010_1_000, 11'b0001010_0_010,
    11'b1011000_1_010, 11'b0010001_0_000, 11'b0001010_0_010, 11'b0101001_0_000,
    11'b0101010_0_000, 11'b0001010_0_000, 11'b1000110_0_000, 11'b0000110_0_000,
    11'b0000110_0_100, 11'b1010001_0_000, 11'b0010010_0_000
  };

  // Port mask the requirements call for under a given grant.
  function automatic logic [NP-1:0] mask_for(logic [2:0] g);
    if (g[0]) return NP'(1) << DP;
    if (g != 3'b000) return {NP{1'b1}};
    return '0;
  endfunction

  function automatic string req_of(int row);
    if (row < 2) return "R1";
    if (row < 9) return "R2/R3";
    if (row < 14) return "R4";
    if (row < 21) return "R5/R6";
    if (row < 30) return "R7";
    return "R7/R2";
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] v);
    {sof, eof, dbg, per, asy, fits, done} = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(gnt == 3'b000, "R1", gnt, 0);
    chk(pen == '0, "R1", pen, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][10:4]);
      #1;
      // R10: flush follows the start strobe while periodic work is pending
      chk(flush == VEC[i][3], {"R10 ", req_of(i)}, flush, VEC[i][3]);
      @(posedge clk); #1;
      chk(gnt == VEC[i][2:0], req_of(i), gnt, VEC[i][2:0]);
      // R8 and R9 on every row
      chk($onehot0(gnt), "R8", gnt, VEC[i][2:0]);
      chk(pen == mask_for(VEC[i][2:0]), "R9", pen, mask_for(VEC[i][2:0]));
    end

    // R1: reset while the debug grant is held clears everything
    drive(7'b1010010);
    @(posedge clk); #1;
    chk(gnt == 3'b001, "R2", gnt, 1);
    chk(pen == 5'b00001, "R9", pen, 1);
    drive(7'b0000000);
    rst_n = 1'b0;
    @(posedge clk); #1;
    chk(gnt == 3'b000, "R1", gnt, 0);
    chk(pen == '0, "R1", pen, 0);
    rst_n = 1'b1;
    // R1: requests without a start strobe stay ungranted
    drive(7'b0011110);
    repeat (3) @(posedge clk);
    #1;
    chk(gnt == 3'b000, "R1", gnt, 0);

    // R3: periodic outranks async right after a frame start
    drive(7'b1001110);
    @(posedge clk); #1;
    drive(7'b0001110);
    @(posedge clk); #1;
    chk(gnt == 3'b010, "R3", gnt, 2);
    chk(pen == 5'b11111, "R9", pen, 31);

    drive(7'b0000000);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule